// File: doc/BRIEF.md
# Capture Buffer Bus Register and Readout Interface

This block sits between a bus master and a capture engine that records a stream of samples into a circular buffer. It is a two-register Wishbone slave on its own bus clock. One register gathers the capture settings, a reset command and the capture status into a single word. The other register returns data. While capture is still running, a data read returns the live input word as it is at that moment. Once capture has stopped, data reads walk through the stored buffer from the oldest sample to the newest. Each read moves the walk forward by one.

The reset command crosses into the capture clock domain as a toggle. The capture side answers with a one-cycle reset pulse and echoes the toggle back. The bus side reports the reset as pending until that echo arrives. The status flags from the capture side reach the bus clock through two-flop synchronizers.

The buffer is read through a synchronous memory port. The address comes from a register, so the memory word arrives in the acknowledge cycle. The bus never applies back-pressure: stall is held low, and every strobed access inside an open cycle is acknowledged on the next clock. The master must keep cyc high through that clock to receive the acknowledge.

Top module: `scope_bus_regs`

## Requirements
- R1: Address 0 selects the control word and address 1 selects the data register. The control word is {bit31 reset pending, bit30 stopped, bit29 triggered, bit28 primed, bit27 manual trigger, bit26 trigger disable, bit25 read-at-first, bits24:20 log2 of the buffer depth, bits19:0 holdoff}. Bits 27, 26 and 19:0 are written by a control write and read back unchanged, and they drive the configuration outputs. Writes to all other bits have no effect on them. After reset the word reads 0x0250_0000 when the depth is 32.
- R2: A control write with bit 31 clear produces exactly one one-cycle `cap_reset` pulse in the capture clock domain. A control write with bit 31 set produces none.
- R3: After a reset command, bit 31 reads 1 until the capture domain has echoed the request back, and then reads 0. A second reset command issued while one is still pending merges into it and adds no further pulse.
- R4: Bits 30, 29 and 28 follow the capture-domain stopped, triggered and primed inputs, within four bus clocks.
- R5: While stopped reads 0, a data read returns the live input word sampled at the access, and the read position does not move.
- R6: While stopped reads 1, the k-th data read returns the memory word at address (oldest + k) modulo the depth. The position advances only on data reads.
- R7: A write to the data register sets the read position back to the oldest sample. The written value changes nothing else.
- R8: Bit 25 reads 1 exactly when the next stopped data read will return the oldest sample. It reads 1 again after depth reads.
- R9: The acknowledge rises on the clock after an access with cyc and stb high. It is withheld if cyc is low in that cycle. Stall is always 0.
- R10: A reset command also sets the read position back to the oldest sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| cap_clk | input | 1 | Capture clock |
| cap_rst_n | input | 1 | Capture-domain asynchronous reset, active low |
| wb_cyc | input | 1 | Bus cycle open |
| wb_stb | input | 1 | Access strobe |
| wb_we | input | 1 | Write when high |
| wb_addr | input | 1 | Register select: 0 control, 1 data |
| wb_wdata | input | 32 | Write data |
| wb_ack | output | 1 | Acknowledge |
| wb_stall | output | 1 | Always 0 |
| wb_rdata | output | 32 | Read data, valid with the acknowledge |
| cap_stopped | input | 1 | Capture has stopped (capture domain) |
| cap_triggered | input | 1 | Trigger seen (capture domain) |
| cap_primed | input | 1 | Buffer filled once (capture domain) |
| live_data | input | DW | Live sample word, not synchronized |
| oldest_addr | input | LGMEM | Buffer address of the oldest sample, stable while stopped |
| mem_raddr | output | LGMEM | Registered-index memory read address |
| mem_rdata | input | DW | Memory word, one bus clock after the address |
| cap_reset | output | 1 | One-cycle reset pulse (capture domain) |
| cfg_holdoff | output | 20 | Holdoff setting |
| cfg_manual | output | 1 | Manual trigger setting |
| cfg_disable | output | 1 | Trigger disable setting |

## Verification
A reset command can arrive while an earlier one is still crossing the clock domains. In that case the new request and the pending echo meet in the same toggle register. The bench provokes this with two reset writes back to back, so the second falls well inside the echo round trip. It then judges two things at the ports: the capture-side pulse counter must rise by exactly one, and bit 31 must first read 1 and later settle to 0. The bench also interleaves data writes and reset commands with stopped reads, and checks that both kinds of rewind bring bit 25 back and restart the sequence at the oldest word.

// File: rtl/scope_regs_pkg.sv
package scope_regs_pkg;
  localparam int CTRL_W = 32;
  localparam int HOLD_W = 20;
  localparam int LOG_W  = 5;
  localparam int BIT_RST = 31;

  typedef struct packed {
    logic              rst_pend;
    logic              stopped;
    logic              fired;
    logic              armed;
    logic              force_trig;
    logic              trig_mask;
    logic              at_first;
    logic [LOG_W-1:0]  depth_log2;
    logic [HOLD_W-1:0] post_count;
  } ctrl_word_t;
endpackage

// File: rtl/scope_sync2.sv
module scope_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/scope_reset_xfer.sv
module scope_reset_xfer (
  input  logic bus_clk,
  input  logic bus_rst_n,
  input  logic cap_clk,
  input  logic cap_rst_n,
  input  logic req,
  output logic pending,
  output logic cap_reset
);
  logic req_tgl_q;
  logic echo_bus;
  logic req_cap;
  logic echo_q;
  logic pulse_q;

  // bus side: toggle once per request, merge while one is in flight
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n)             req_tgl_q <= 1'b0;
    else if (req && !pending)   req_tgl_q <= ~req_tgl_q;
  end

  scope_sync2 #(.W(1)) u_to_cap (
    .clk(cap_clk), .rst_n(cap_rst_n), .d(req_tgl_q), .q(req_cap)
  );

  // capture side: edge of the synced toggle makes the pulse, echo returns it
  always_ff @(posedge cap_clk or negedge cap_rst_n) begin
    if (!cap_rst_n) begin
      echo_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      echo_q  <= req_cap;
      pulse_q <= req_cap ^ echo_q;
    end
  end

  scope_sync2 #(.W(1)) u_to_bus (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(echo_q), .q(echo_bus)
  );

  assign pending   = req_tgl_q ^ echo_bus;
  assign cap_reset = pulse_q;

  p_single_pulse_r2: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
    cap_reset |=> !cap_reset);

  // R3: the echo needs several clocks, so pending never drops right after rising
  p_pend_hold_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(pending) |=> pending);
endmodule

// File: rtl/scope_readout.sv
module scope_readout #(
  parameter int DW    = 32,
  parameter int LGMEM = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             rewind,
  input  logic             stopped,
  input  logic [LGMEM-1:0] base,
  input  logic [DW-1:0]    live,
  input  logic [DW-1:0]    mem_rdata,
  output logic [LGMEM-1:0] mem_raddr,
  output logic             at_first,
  output logic [DW-1:0]    data_word
);
  logic [LGMEM-1:0] rd_idx_q;
  logic [DW-1:0]    live_q;
  logic             from_mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_idx_q <= '0;
    else if (rewind)           rd_idx_q <= '0;
    else if (fire && stopped)  rd_idx_q <= rd_idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q     <= '0;
      from_mem_q <= 1'b0;
    end else if (fire) begin
      live_q     <= live;
      from_mem_q <= stopped;
    end
  end

  assign mem_raddr = base + rd_idx_q;
  assign at_first  = (rd_idx_q == '0);
  assign data_word = from_mem_q ? mem_rdata : live_q;

  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire || rewind) |=> $stable(rd_idx_q));

  p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (rd_idx_q == '0));
endmodule

// File: rtl/scope_bus_regs.sv
module scope_bus_regs
  import scope_regs_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LGMEM = 5
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             cap_clk,
  input  logic             cap_rst_n,
  input  logic             wb_cyc,
  input  logic             wb_stb,
  input  logic             wb_we,
  input  logic             wb_addr,
  input  logic [31:0]      wb_wdata,
  output logic             wb_ack,
  output logic             wb_stall,
  output logic [31:0]      wb_rdata,
  input  logic             cap_stopped,
  input  logic             cap_triggered,
  input  logic             cap_primed,
  input  logic [DW-1:0]    live_data,
  input  logic [LGMEM-1:0] oldest_addr,
  output logic [LGMEM-1:0] mem_raddr,
  input  logic [DW-1:0]    mem_rdata,
  output logic             cap_reset,
  output logic [19:0]      cfg_holdoff,
  output logic             cfg_manual,
  output logic             cfg_disable
);
  localparam logic [LOG_W-1:0] DEPTH_CODE = LOG_W'(LGMEM);

  logic             access, ctrl_wr, data_wr, data_rd, rst_cmd;
  logic [2:0]       stat_sync;
  logic             pending, at_first;
  logic [DW-1:0]    data_word;
  logic [HOLD_W-1:0] hold_q;
  logic             manual_q, mask_q;
  ctrl_word_t       ctrl_now, ctrl_q;
  logic             sel_ctrl_q, ack_q;

  assign access  = wb_cyc && wb_stb;
  assign ctrl_wr = access && wb_we && !wb_addr;
  assign data_wr = access && wb_we && wb_addr;
  assign data_rd = access && !wb_we && wb_addr;
  assign rst_cmd = ctrl_wr && !wb_wdata[BIT_RST];

  scope_sync2 #(.W(3)) u_stat_sync (
    .clk(bus_clk), .rst_n(bus_rst_n),
    .d({cap_stopped, cap_triggered, cap_primed}), .q(stat_sync)
  );

  scope_reset_xfer u_rst_xfer (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .cap_clk(cap_clk), .cap_rst_n(cap_rst_n),
    .req(rst_cmd), .pending(pending), .cap_reset(cap_reset)
  );

  scope_readout #(.DW(DW), .LGMEM(LGMEM)) u_readout (
    .clk(bus_clk), .rst_n(bus_rst_n),
    .fire(data_rd), .rewind(data_wr || rst_cmd),
    .stopped(stat_sync[2]), .base(oldest_addr), .live(live_data),
    .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .at_first(at_first), .data_word(data_word)
  );

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      hold_q   <= '0;
      manual_q <= 1'b0;
      mask_q   <= 1'b0;
    end else if (ctrl_wr) begin
      hold_q   <= wb_wdata[HOLD_W-1:0];
      manual_q <= wb_wdata[27];
      mask_q   <= wb_wdata[26];
    end
  end

  always_comb begin
    ctrl_now            = '0;
    ctrl_now.rst_pend   = pending;
    ctrl_now.stopped    = stat_sync[2];
    ctrl_now.fired      = stat_sync[1];
    ctrl_now.armed      = stat_sync[0];
    ctrl_now.force_trig = manual_q;
    ctrl_now.trig_mask  = mask_q;
    ctrl_now.at_first   = at_first;
    ctrl_now.depth_log2 = DEPTH_CODE;
    ctrl_now.post_count = hold_q;
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      ack_q      <= 1'b0;
      sel_ctrl_q <= 1'b1;
      ctrl_q     <= '0;
    end else begin
      ack_q <= access;
      if (access) begin
        sel_ctrl_q <= !wb_addr;
        ctrl_q     <= ctrl_now;
      end
    end
  end

  assign wb_ack      = ack_q && wb_cyc;
  assign wb_stall    = 1'b0;
  assign wb_rdata    = sel_ctrl_q ? 32'(ctrl_q) : 32'(data_word);
  assign cfg_holdoff = hold_q;
  assign cfg_manual  = manual_q;
  assign cfg_disable = mask_q;

  p_ack_origin_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    wb_ack |-> $past(wb_cyc && wb_stb));

  p_cfg_kept_r1: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !ctrl_wr |=> $stable(cfg_holdoff) && $stable(cfg_manual) && $stable(cfg_disable));
endmodule

// File: tb/scope_bus_regs_tb_top.sv
module scope_bus_regs_tb_top;
  localparam int DW = 32;
  localparam int LGMEM = 5;
  localparam int DEPTH = 1 << LGMEM;

  logic bus_clk = 0, cap_clk = 0, bus_rst_n = 0, cap_rst_n = 0;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0, wb_addr = 0;
  logic [31:0] wb_wdata = '0;
  logic wb_ack, wb_stall;
  logic [31:0] wb_rdata;
  logic cap_stopped = 0, cap_triggered = 0, cap_primed = 0;
  logic [DW-1:0] live_data = '0;
  logic [LGMEM-1:0] oldest_addr = 5'd27;
  logic [LGMEM-1:0] mem_raddr;
  logic [DW-1:0] mem_rdata = '0;
  logic cap_reset;
  logic [19:0] cfg_holdoff;
  logic cfg_manual, cfg_disable;

  int checks = 0, errors = 0, pulses = 0;

  always #4 bus_clk = ~bus_clk;
  always #5.5 cap_clk = ~cap_clk;

  scope_bus_regs #(.DW(DW), .LGMEM(LGMEM)) dut_i (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .cap_clk(cap_clk), .cap_rst_n(cap_rst_n),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_addr(wb_addr),
    .wb_wdata(wb_wdata), .wb_ack(wb_ack), .wb_stall(wb_stall), .wb_rdata(wb_rdata),
    .cap_stopped(cap_stopped), .cap_triggered(cap_triggered), .cap_primed(cap_primed),
    .live_data(live_data), .oldest_addr(oldest_addr), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .cap_reset(cap_reset), .cfg_holdoff(cfg_holdoff),
    .cfg_manual(cfg_manual), .cfg_disable(cfg_disable)
  );

  function automatic logic [31:0] memf(input int k);
    return 32'hA500_0000 + 32'(k * 7 + 3);
  endfunction

  always @(posedge bus_clk) mem_rdata <= memf(int'(mem_raddr));
  always @(posedge cap_clk) if (cap_reset) pulses <= pulses + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic adr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic ackd);
    @(negedge bus_clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_addr = adr; wb_wdata = wd;
    @(negedge bus_clk);
    wb_stb = 0; ackd = wb_ack; rd = wb_rdata; wb_cyc = 0; wb_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic t_reset_state;
    logic [31:0] rd; logic a;
    bus_op(0, 0, 0, rd, a);
    chk("R1 reset word", rd, 32'h0250_0000);
    chk("R9 ack", 32'(a), 1);
    chk("R9 stall", 32'(wb_stall), 0);
    chk("R2 no pulse at start", pulses, 0);
  endtask

  task automatic t_config;
    logic [31:0] rd; logic a;
    bus_op(1, 0, 32'h8C01_2345, rd, a);
    bus_op(0, 0, 0, rd, a);
    chk("R1 readback", rd, 32'h0E51_2345);
    chk("R1 cfg outputs", {cfg_manual, cfg_disable, 10'd0, cfg_holdoff}, {2'b11, 10'd0, 20'h12345});
    idle(20);
    chk("R2 bit31 set gives no pulse", pulses, 0);
  endtask

  task automatic t_reset_cmd;
    logic [31:0] rd; logic a; int p0;
    p0 = pulses;
    bus_op(1, 0, 32'h0C01_2345, rd, a);
    bus_op(0, 0, 0, rd, a);
    chk("R3 pending after command", 32'(rd[31]), 1);
    idle(30);
    bus_op(0, 0, 0, rd, a);
    chk("R3 pending cleared", 32'(rd[31]), 0);
    chk("R2 one pulse", pulses, p0 + 1);
  endtask

  task automatic t_double;
    logic [31:0] rd; logic a; int p0;
    p0 = pulses;
    bus_op(1, 0, 32'h0C01_2345, rd, a);
    bus_op(1, 0, 32'h0C01_2345, rd, a);
    bus_op(0, 0, 0, rd, a);
    chk("R3 pending during merge", 32'(rd[31]), 1);
    idle(30);
    bus_op(0, 0, 0, rd, a);
    chk("R3 merged cleared", 32'(rd[31]), 0);
    chk("R3 merged single pulse", pulses, p0 + 1);
  endtask

  task automatic t_status;
    logic [31:0] rd; logic a;
    cap_primed = 1; idle(4);
    bus_op(0, 0, 0, rd, a);
    chk("R4 primed", 32'(rd[30:28]), 1);
    cap_triggered = 1; idle(4);
    bus_op(0, 0, 0, rd, a);
    chk("R4 triggered", 32'(rd[30:28]), 3);
  endtask

  task automatic t_live;
    logic [31:0] rd; logic a;
    live_data = 32'hDEAD_BEEF;
    bus_op(0, 1, 0, rd, a);
    chk("R5 live read", rd, 32'hDEAD_BEEF);
    live_data = 32'h1357_2468;
    bus_op(0, 1, 0, rd, a);
    chk("R5 live read 2", rd, 32'h1357_2468);
    bus_op(0, 0, 0, rd, a);
    chk("R5 position unmoved", 32'(rd[25]), 1);
  endtask

  task automatic t_stream;
    logic [31:0] rd; logic a;
    cap_stopped = 1; idle(4);
    bus_op(0, 0, 0, rd, a);
    chk("R4 stopped", 32'(rd[30:28]), 7);
    for (int k = 0; k < DEPTH; k++) begin
      bus_op(0, 1, 0, rd, a);
      chk("R6 stored word", rd, memf((27 + k) % DEPTH));
      if (k == 0) begin
        bus_op(0, 0, 0, rd, a);
        chk("R8 not at first after one read", 32'(rd[25]), 0);
      end
    end
    bus_op(0, 0, 0, rd, a);
    chk("R8 at first after full walk", 32'(rd[25]), 1);
  endtask

  task automatic t_rewind;
    logic [31:0] rd; logic a;
    for (int k = 0; k < 3; k++) bus_op(0, 1, 0, rd, a);
    bus_op(1, 1, 32'hFFFF_FFFF, rd, a);
    bus_op(0, 0, 0, rd, a);
    chk("R7 rewind word unchanged", rd, 32'h7E51_2345);
    bus_op(0, 1, 0, rd, a);
    chk("R7 oldest after rewind", rd, memf(27));
  endtask

  task automatic t_rst_rewind;
    logic [31:0] rd; logic a;
    bus_op(0, 1, 0, rd, a);
    bus_op(1, 0, 32'h0C01_2345, rd, a);
    idle(30);
    bus_op(0, 0, 0, rd, a);
    chk("R10 reset rewinds", rd, 32'h7E51_2345);
    bus_op(0, 1, 0, rd, a);
    chk("R10 oldest after reset", rd, memf(27));
  endtask

  task automatic t_abandon;
    @(negedge bus_clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_addr = 0;
    @(negedge bus_clk);
    wb_stb = 0; wb_cyc = 0;
    #1;
    chk("R9 ack withheld", 32'(wb_ack), 0);
  endtask

  initial begin
    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1; cap_rst_n = 1;
    idle(2);
    t_reset_state();
    t_config();
    t_reset_cmd();
    t_double();
    t_status();
    t_live();
    t_stream();
    t_rewind();
    t_rst_rewind();
    t_abandon();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bus_clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule